// File: doc/BRIEF.md
# Time-of-Flight Histogram Bin Bank with Serial Drain

This block accumulates a histogram of photon arrival times and then streams it out without a separate readout memory. During acquisition, every strobe carries a bin address. The addressed bin counter goes up by one, and it stops at its maximum value instead of wrapping around.

When acquisition ends, the controller switches the bank to drain mode. In drain mode the same counters form a chain that moves toward a single output port. On every enabled clock, one bin leaves the chain, starting with bin 0. A streaming consumer, such as a peak or centroid finder, can therefore process the bins in time order with no buffer of its own.

Zeros fill the chain from the far end. After a complete drain the bank is empty and ready for the next acquisition. A synchronous clear input empties the bank at any time.

Top module: `hist_shift_bank`

## Requirements
- R1: After reset, every bin holds 0, `bin_valid` is 0 and `bin_out` is 0.
- R2: With `shift_mode` = 0, a one-cycle high on `strobe` adds exactly one to the bin whose index equals the binary value of `bin_addr` (bin k at address k). No other bin changes. A strobe held high for n cycles counts n events.
- R3: A bin that holds 255 stays at 255 on further strobes.
- R4: With `shift_mode` = 1, `strobe` has no effect on any bin, and `bin_out` does not change in a cycle without `shift_en`.
- R5: In drain mode, `bin_out` first shows bin 0. Each clock with `shift_en` high advances the output to the next bin index in the cycle that follows. A clock with `shift_en` low holds the current bin.
- R6: `bin_valid` goes high combinationally with `shift_mode` = 1. It stays high until 128 enabled shifts have been taken, then stays low until `shift_mode` returns to 0. While `bin_valid` is 0, `bin_out` is 0. While `shift_mode` = 0, `shift_en` has no effect.
- R7: Zeros enter the chain behind the last bin, so a second drain with no strobes in between reads 128 zeros.
- R8: `clear` high at a clock edge sets every bin to 0, and this overrides a strobe in the same cycle.
- R9: Once all 128 bins have been drained, further `shift_en` pulses leave `bin_valid` low and `bin_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_addr | input | 7 | Bin index for the current strobe |
| strobe | input | 1 | One-cycle event pulse; counts in count mode |
| shift_mode | input | 1 | 0 = count, 1 = drain |
| shift_en | input | 1 | Advances the chain by one bin in drain mode |
| clear | input | 1 | Synchronous clear of every bin |
| bin_out | output | 8 | Value of the bin at the head of the chain |
| bin_valid | output | 1 | High while `bin_out` carries an undrained bin |

## Verification
The following properties are checked on every cycle:
- the address decoder produces exactly one select bit, and that bit matches the address;
- a head bin at 255 holds;
- a strobe adds one to the head bin;
- the head bin is empty after a clear;
- the output stays frozen in drain mode when no shift occurs;
- `bin_valid` covers exactly the first 128 accepted shifts.

Some properties depend on the whole bank and can only be shown by the bench scenarios:
- every bin value appears in index order;
- pauses in `shift_en` hold the output;
- strobes during a drain corrupt nothing;
- the bank reads back empty after a drain or a clear.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_SHIFT = 1'b1
  } hsb_mode_e;

  // Saturating increment: the result never exceeds top.
  function automatic int unsigned sat_next(input int unsigned v, input int unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction

  // True while fewer than n bins have left the chain.
  function automatic logic drain_pending(input int unsigned taken, input int unsigned n);
    return taken < n;
  endfunction

endpackage

// File: rtl/hsb_addr_decode.sv
module hsb_addr_decode #(
  parameter int NUM_BINS = 128,
  parameter int ADDR_W   = $clog2(NUM_BINS)
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_BINS-1:0] onehot
);
  for (genvar g = 0; g < NUM_BINS; g++) begin : g_sel
    assign onehot[g] = (addr == ADDR_W'(g));
  end
endmodule

// File: rtl/hsb_bin_cell.sv
module hsb_bin_cell #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sel,
  input  logic             cnt_fire,
  input  logic             shift_fire,
  input  logic [CNT_W-1:0] shift_in,
  output logic [CNT_W-1:0] val
);
  import hsb_pkg::*;

  localparam int unsigned TOP = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] val_q;
  logic [CNT_W-1:0] inc_val;

  assign inc_val = CNT_W'(sat_next(int'(val_q), TOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                val_q <= '0;
    else if (clear)            val_q <= '0;
    else if (shift_fire)       val_q <= shift_in;
    else if (cnt_fire && sel)  val_q <= inc_val;
  end

  assign val = val_q;
endmodule

// File: rtl/hsb_readout_ctl.sv
module hsb_readout_ctl #(
  parameter int NUM_BINS = 128,
  parameter int ADDR_W   = $clog2(NUM_BINS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_mode,
  input  logic shift_en,
  output logic rd_active,
  output logic shift_fire
);
  import hsb_pkg::*;

  logic [ADDR_W:0] taken_q;

  assign rd_active  = shift_mode && drain_pending(int'(taken_q), NUM_BINS);
  assign shift_fire = rd_active && shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          taken_q <= '0;
    else if (!shift_mode) taken_q <= '0;
    else if (shift_fire)  taken_q <= taken_q + 1'b1;
  end
endmodule

// File: rtl/hist_shift_bank.sv
module hist_shift_bank #(
  parameter int NUM_BINS = 128,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = $clog2(NUM_BINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bin_addr,
  input  logic              strobe,
  input  logic              shift_mode,
  input  logic              shift_en,
  input  logic              clear,
  output logic [CNT_W-1:0]  bin_out,
  output logic              bin_valid
);
  import hsb_pkg::*;

  logic [NUM_BINS-1:0] sel_vec;
  logic [CNT_W-1:0]    bin_val  [NUM_BINS];
  logic [CNT_W-1:0]    chain_in [NUM_BINS];
  logic                cnt_fire;
  logic                shift_fire;
  logic                rd_active;
  logic [CNT_W-1:0]    head_val;

  assign cnt_fire = strobe && (hsb_mode_e'(shift_mode) == MODE_COUNT);

  hsb_addr_decode #(.NUM_BINS(NUM_BINS), .ADDR_W(ADDR_W)) u_dec (
    .addr   (bin_addr),
    .onehot (sel_vec)
  );

  hsb_readout_ctl #(.NUM_BINS(NUM_BINS), .ADDR_W(ADDR_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_mode (shift_mode),
    .shift_en   (shift_en),
    .rd_active  (rd_active),
    .shift_fire (shift_fire)
  );

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
    if (g == NUM_BINS - 1) begin : g_tail
      assign chain_in[g] = '0;
    end else begin : g_link
      assign chain_in[g] = bin_val[g+1];
    end

    hsb_bin_cell #(.CNT_W(CNT_W)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .sel        (sel_vec[g]),
      .cnt_fire   (cnt_fire),
      .shift_fire (shift_fire),
      .shift_in   (chain_in[g]),
      .val        (bin_val[g])
    );
  end

  assign head_val  = bin_val[0];
  assign bin_out   = rd_active ? head_val : '0;
  assign bin_valid = rd_active;
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
  parameter int NUM_BINS = 128,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = $clog2(NUM_BINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bin_addr,
  input logic                shift_mode,
  input logic                shift_en,
  input logic                clear,
  input logic [CNT_W-1:0]    bin_out,
  input logic                bin_valid,
  input logic [NUM_BINS-1:0] sel_vec,
  input logic [CNT_W-1:0]    head_val,
  input logic                shift_fire,
  input logic                cnt_fire
);
  localparam logic [CNT_W-1:0] TOPV = {CNT_W{1'b1}};

  logic [ADDR_W+1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen_q <= '0;
    else if (!shift_mode) seen_q <= '0;
    else if (shift_fire)  seen_q <= seen_q + 1'b1;
  end

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sel_vec) == 1) && sel_vec[bin_addr]);

  p_head_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fire && sel_vec[0] && !clear && head_val != TOPV) |=>
      head_val == CNT_W'($past(head_val) + 1'b1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (head_val == TOPV && !shift_fire && !clear) |=> head_val == TOPV);

  p_hold_in_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_mode && !shift_en && !clear) ##1 shift_mode |-> $stable(bin_out));

  p_valid_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_mode && seen_q < NUM_BINS) |-> bin_valid);

  p_valid_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q >= NUM_BINS || !shift_mode) |-> !bin_valid);

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bin_valid |-> bin_out == '0);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> head_val == '0);
endmodule

bind hist_shift_bank hsb_checker #(
  .NUM_BINS (NUM_BINS),
  .CNT_W    (CNT_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bin_addr   (bin_addr),
  .shift_mode (shift_mode),
  .shift_en   (shift_en),
  .clear      (clear),
  .bin_out    (bin_out),
  .bin_valid  (bin_valid),
  .sel_vec    (sel_vec),
  .head_val   (head_val),
  .shift_fire (shift_fire),
  .cnt_fire   (cnt_fire)
);

// File: tb/sim_hist_shift_bank.sv
`timescale 1ns/1ps
module sim_hist_shift_bank;
  localparam int N   = 128;
  localparam int TOP = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] bin_addr = '0;
  logic       strobe = 1'b0;
  logic       shift_mode = 1'b0;
  logic       shift_en = 1'b0;
  logic       clear = 1'b0;
  logic [7:0] bin_out;
  logic       bin_valid;

  int exp_bin [N];
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hist_shift_bank u0 (
    .clk(clk), .rst_n(rst_n), .bin_addr(bin_addr), .strobe(strobe),
    .shift_mode(shift_mode), .shift_en(shift_en), .clear(clear),
    .bin_out(bin_out), .bin_valid(bin_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pulse(input int a);
    @(negedge clk);
    bin_addr = 7'(a);
    strobe   = 1'b1;
    exp_bin[a] = (exp_bin[a] >= TOP) ? TOP : exp_bin[a] + 1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  // Drain all bins and compare against the model; optional pauses and strobe noise.
  task automatic drain(input string req, input bit gaps, input bit noise);
    @(negedge clk);
    shift_mode = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (gaps && (i % 5 == 2)) begin
        shift_en = 1'b0;
        strobe   = noise;
        bin_addr = 7'(i);
        #1;
        chk(bin_out == 8'(exp_bin[i]), {req, " R4 hold without shift"}, bin_out, exp_bin[i]);
        @(negedge clk);
      end
      shift_en = 1'b1;
      strobe   = noise;
      bin_addr = 7'((i * 11) % N);
      #1;
      chk(bin_valid == 1'b1, {req, " R6 valid"}, bin_valid, 1);
      chk(bin_out == 8'(exp_bin[i]), {req, " R5 bin order"}, bin_out, exp_bin[i]);
      @(negedge clk);
    end
    strobe = 1'b0;
    shift_en = 1'b1;
    #1;
    chk(bin_valid == 1'b0, {req, " R9 valid after drain"}, bin_valid, 0);
    chk(bin_out == 8'd0, {req, " R9 out after drain"}, bin_out, 0);
    @(negedge clk);
    #1;
    chk(bin_valid == 1'b0, {req, " R9 extra shift"}, bin_valid, 0);
    @(negedge clk);
    shift_en = 1'b0;
    shift_mode = 1'b0;
    for (int i = 0; i < N; i++) exp_bin[i] = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(bin_valid == 1'b0, "R1 valid", bin_valid, 0);
    chk(bin_out == 8'd0, "R1 out", bin_out, 0);
    drain("R1 empty bank", 1'b0, 1'b0);
  endtask

  task automatic t_count_pattern;
    // shift_en held high in count mode must be ignored (R6)
    shift_en = 1'b1;
    for (int i = 0; i < N; i++)
      for (int k = 0; k < (i * 7) % 5; k++) pulse(i);
    // back-to-back strobes on changing addresses (R2)
    @(negedge clk);
    strobe = 1'b1;
    for (int i = 0; i < 6; i++) begin
      bin_addr = 7'(i * 20);
      exp_bin[i * 20] = exp_bin[i * 20] + 1;
      @(negedge clk);
    end
    strobe = 1'b0;
    shift_en = 1'b0;
    drain("R2 count pattern", 1'b0, 1'b0);
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 300; k++) pulse(0);
    for (int k = 0; k < 260; k++) pulse(127);
    pulse(64);
    drain("R3 saturation", 1'b1, 1'b0);
  endtask

  task automatic t_drain_noise;
    for (int i = 0; i < N; i += 3) pulse(i);
    pulse(1); pulse(1);
    drain("R4 strobe during drain", 1'b1, 1'b1);
    drain("R7 second drain empty", 1'b0, 1'b0);
  endtask

  task automatic t_clear;
    for (int i = 0; i < N; i += 2) pulse(i);
    @(negedge clk);
    clear = 1'b1;
    strobe = 1'b1;
    bin_addr = 7'd3;
    @(negedge clk);
    clear = 1'b0;
    strobe = 1'b0;
    for (int i = 0; i < N; i++) exp_bin[i] = 0;
    pulse(9);
    drain("R8 clear", 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) exp_bin[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_pattern();
    t_saturate();
    t_drain_noise();
    t_clear();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule